// File: doc/BRIEF.md
# Password-Protected Fractional Clock Mux

This block picks one of up to sixteen clock-enable pulse streams and passes a thinned copy of it to a peripheral. All logic runs on one system clock, and each source clock is modelled as a one-cycle enable pulse on that clock. The output is another pulse stream of the same kind. Its average rate is the selected source rate times 2^FRAC_BITS, divided by a programmed divisor that has an integer part and a fractional part.

Software programs the block through two 32-bit registers on a simple register bus:
- The control register holds a source select, an enable and a read-only busy flag.
- The divide register holds the divisor. The integer part starts at bit 12 and runs upward. The fractional part sits in the FRAC_BITS bits just below bit 12.

A register changes only when the top byte of the write data carries a fixed key. The key bits are never stored.

The bus has no back-pressure. A request is taken in the cycle it is presented. Reads return data in that same cycle. Writes take effect at the next clock edge.

Source slot 0 is tied to ground. Slot 1 is meant for the crystal reference, slots 2 and 3 for two test clocks, and the higher slots are free for each instance to assign.

Top module: `pwclk_mux`

## Requirements
- R1: After reset, the control register at offset 0x0 and the divide register at offset 0x4 both read zero, and `clk_en_out` stays low.
- R2: A write whose data bits 31:24 differ from 8'h5A changes no register.
- R3: An accepted write stores the value with bits 31:24 cleared, so a readback shows those bits as zero.
- R4: A bus access counts only if `bus_be` is 4'hF and `bus_addr[1:0]` is zero. Other accesses write nothing and read zero. Offsets other than 0x0 and 0x4 also read zero and ignore writes.
- R5: Control register fields are: SRC in bits 3:0, ENABLE in bit 4, and BUSY in bit 5. BUSY is read-only. After every accepted write to either register, BUSY equals ENABLE.
- R6: While ENABLE is clear, `clk_en_out` emits no pulse.
- R7: SRC value 0 selects ground and produces no output. SRC value i, for i from 1 to 15, follows `src_en[i]` only. Pulses on other sources have no effect.
- R8: Let D be the divide register bits 23:0, which are the 12-bit integer part over the 12-bit fractional part. After an accepted write, if D is greater than 4096, N pulses of the selected source give exactly floor(N*4096/D) output pulses. If D is between 1 and 4096, every source pulse is passed.
- R9: If D is zero, the output emits no pulse.
- R10: Each output pulse appears exactly one cycle after the selected source pulse that produced it. Pulses present during the cycle of an accepted write are dropped, and the phase accumulator restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| bus_rdata | output | 32 | Read data, valid in the cycle of the request |
| src_en | input | 16 | One enable pulse stream per source slot |
| clk_en_out | output | 1 | Divided output enable pulse stream |

## Verification
The assertions assume that software changes the configuration only while the output runs. When a write and a source pulse collide, the write wins, and the bench leaves `src_en` low during every bus cycle so that pulse counts stay exact. Random runs draw the divisor, the source slot and the pulse density from `$urandom` with a fixed seed. The divisors span both sides of 4096 and include zero. Each run drives a random pattern on every source and counts only the pulses on the selected slot.

// File: rtl/pwclk_pkg.sv
package pwclk_pkg;
  localparam logic [7:0] KEY       = 8'h5A;
  localparam int         KEY_LSB   = 24;
  localparam int         STORE_W   = 24;
  localparam int         DIV_POINT = 12;
  localparam int         SRC_FLD_W = 4;
  localparam int         EN_BIT    = 4;
  localparam int         BUSY_BIT  = 5;
  localparam logic [1:0] OFF_CTL   = 2'd0;
  localparam logic [1:0] OFF_DIV   = 2'd1;
endpackage

// File: rtl/pwclk_regs.sv
module pwclk_regs
  import pwclk_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [SRC_FLD_W-1:0] src_sel,
  output logic                 enable,
  output logic [STORE_W-1:0]   div_raw,
  output logic                 reeval
);
  logic                 access_ok, key_ok, wr_ok, hit_ctl, hit_div;
  logic [SRC_FLD_W-1:0] src_q;
  logic                 en_q, busy_q;
  logic [STORE_W-1:0]   div_q;

  assign access_ok = bus_req && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign hit_ctl   = (bus_addr[ADDR_W-1:2] == {{(ADDR_W-4){1'b0}}, OFF_CTL});
  assign hit_div   = (bus_addr[ADDR_W-1:2] == {{(ADDR_W-4){1'b0}}, OFF_DIV});
  assign key_ok    = (bus_wdata[31:KEY_LSB] == KEY);
  assign wr_ok     = access_ok && bus_we && key_ok && (hit_ctl || hit_div);
  assign reeval    = wr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      div_q  <= '0;
    end else if (wr_ok) begin
      if (hit_ctl) begin
        src_q  <= bus_wdata[SRC_FLD_W-1:0];
        en_q   <= bus_wdata[EN_BIT];
        busy_q <= bus_wdata[EN_BIT];
      end else begin
        div_q  <= bus_wdata[STORE_W-1:0];
        busy_q <= en_q;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (access_ok && !bus_we) begin
      if (hit_ctl) begin
        bus_rdata[SRC_FLD_W-1:0] = src_q;
        bus_rdata[EN_BIT]        = en_q;
        bus_rdata[BUSY_BIT]      = busy_q;
      end else if (hit_div) begin
        bus_rdata[STORE_W-1:0]   = div_q;
      end
    end
  end

  assign src_sel = src_q;
  assign enable  = en_q;
  assign div_raw = div_q;

  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !key_ok) |=> ($stable(src_q) && $stable(en_q) && $stable(div_q)));

  assert_busy_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (busy_q == en_q));
endmodule

// File: rtl/pwclk_srcsel.sv
module pwclk_srcsel
  import pwclk_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic [NSRC-1:0]      src_en,
  input  logic [SRC_FLD_W-1:0] src_sel,
  output logic                 sel_pulse
);
  logic [NSRC-1:0] usable;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_slot
      if (i == 0) begin : g_gnd
        assign usable[i] = 1'b0;
      end else begin : g_live
        assign usable[i] = src_en[i] && (src_sel == SRC_FLD_W'(i));
      end
    end
  endgenerate

  assign sel_pulse = |usable;
endmodule

// File: rtl/pwclk_fracdiv.sv
module pwclk_fracdiv
  import pwclk_pkg::*;
#(
  parameter int INT_BITS  = 12,
  parameter int FRAC_BITS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               run,
  input  logic               src_pulse,
  input  logic [STORE_W-1:0] div_raw,
  output logic               pulse_out
);
  localparam int D_W = INT_BITS + FRAC_BITS;

  generate
    if (D_W == 0) begin : g_pass
      always_ff @(posedge clk) begin
        if (!rst_n || clr) pulse_out <= 1'b0;
        else               pulse_out <= run && src_pulse;
      end
    end else begin : g_frac
      localparam int              ACC_W = D_W + 2;
      localparam logic [ACC_W-1:0] ONE  = ACC_W'(1) << FRAC_BITS;
      localparam int              TOP   = DIV_POINT + INT_BITS - 1;

      logic [D_W-1:0]   dval;
      logic [ACC_W-1:0] dext, acc, sum;

      assign dval = div_raw[TOP -: D_W];
      assign dext = ACC_W'(dval);
      assign sum  = acc + ONE;

      always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
          acc       <= '0;
          pulse_out <= 1'b0;
        end else if (src_pulse && dval != '0) begin
          if (dext <= ONE) begin
            acc       <= '0;
            pulse_out <= 1'b1;
          end else if (sum >= dext) begin
            acc       <= sum - dext;
            pulse_out <= 1'b1;
          end else begin
            acc       <= sum;
            pulse_out <= 1'b0;
          end
        end else begin
          pulse_out <= 1'b0;
        end
      end

      assert_zero_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> $past(dval != '0));
    end
  endgenerate

  assert_one_per_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> $past(src_pulse && run));
endmodule

// File: rtl/pwclk_mux.sv
module pwclk_mux
  import pwclk_pkg::*;
#(
  parameter int NSRC      = 16,
  parameter int ADDR_W    = 4,
  parameter int INT_BITS  = 12,
  parameter int FRAC_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_en,
  output logic              clk_en_out
);
  logic [SRC_FLD_W-1:0] src_sel;
  logic                 enable, reeval, sel_pulse;
  logic [STORE_W-1:0]   div_raw;

  pwclk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_sel(src_sel), .enable(enable),
    .div_raw(div_raw), .reeval(reeval)
  );

  pwclk_srcsel #(.NSRC(NSRC)) u_sel (
    .src_en(src_en), .src_sel(src_sel), .sel_pulse(sel_pulse)
  );

  pwclk_fracdiv #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(reeval), .run(enable),
    .src_pulse(sel_pulse), .div_raw(div_raw), .pulse_out(clk_en_out)
  );

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> $past(enable));

  assert_no_ground_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> $past(src_sel != '0));
endmodule

// File: tb/pwclk_mux_bench.sv
module pwclk_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] src_en = '0;
  logic        clk_en_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwclk_mux u_pwclk_mux (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_en(src_en), .clk_en_out(clk_en_out)
  );

  function automatic longint exp_count(longint n, longint d);
    if (d == 0) return 0;
    if (d <= 4096) return n;
    return (n * 4096) / d;
  endfunction

  function automatic logic [31:0] ctl_word(logic [7:0] key, logic busy, logic en, logic [3:0] src);
    return {key, 18'h0, busy, en, src};
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic run(int n, int sel, int dens, output longint got, output longint srcn);
    got = 0; srcn = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got += clk_en_out;
      for (int b = 0; b < 16; b++) src_en[b] = (($urandom % 100) < dens);
      if (sel != 0 && src_en[sel]) srcn++;
    end
    @(negedge clk);
    got += clk_en_out;
    src_en = '0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    longint got, srcn;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(4'h0, r); check("R1 ctl", r, 0);
    rd(4'h4, r); check("R1 div", r, 0);
    check("R1 out", clk_en_out, 0);

    // R2 wrong key dropped
    wr(4'h4, {8'hA5, 24'h001234});
    rd(4'h4, r); check("R2 div unchanged", r, 0);
    wr(4'h0, ctl_word(8'h5B, 0, 1, 4'd3));
    rd(4'h0, r); check("R2 ctl unchanged", r, 0);

    // R3 key stripped
    wr(4'h4, {8'h5A, 24'hC0FFEE});
    rd(4'h4, r); check("R3 readback", r, 32'h00C0FFEE);

    // R4 partial / misaligned / unmapped
    wr(4'h4, {8'h5A, 24'h000111}, 4'h3);
    rd(4'h4, r); check("R4 partial write", r, 32'h00C0FFEE);
    wr(4'h5, {8'h5A, 24'h000222});
    rd(4'h4, r); check("R4 misaligned write", r, 32'h00C0FFEE);
    rd(4'h4, r, 4'h1); check("R4 partial read", r, 0);
    wr(4'h8, {8'h5A, 24'h000333});
    rd(4'h8, r); check("R4 unmapped", r, 0);

    // R5 busy mirrors enable, write to busy ignored
    wr(4'h0, ctl_word(8'h5A, 1, 0, 4'd2));
    rd(4'h0, r); check("R5 busy clear", r, 32'h02);
    wr(4'h0, ctl_word(8'h5A, 0, 1, 4'd2));
    rd(4'h0, r); check("R5 busy set", r, 32'h32);

    // R6 enable clear, divisor passes all
    wr(4'h4, {8'h5A, 24'h001000});
    wr(4'h0, ctl_word(8'h5A, 0, 0, 4'd5));
    run(200, 5, 60, got, srcn); check("R6 disabled count", got, 0);

    // R7 ground slot and selective source
    wr(4'h0, ctl_word(8'h5A, 0, 1, 4'd0));
    run(200, 0, 80, got, srcn); check("R7 ground count", got, 0);
    wr(4'h0, ctl_word(8'h5A, 0, 1, 4'd9));
    run(300, 9, 40, got, srcn); check("R7 slot 9 count", got, srcn);

    // R9 zero divisor
    wr(4'h4, {8'h5A, 24'h000000});
    run(200, 9, 70, got, srcn); check("R9 zero div", got, 0);

    // R10 latency
    wr(4'h4, {8'h5A, 24'h001000});
    @(negedge clk); src_en[9] = 1;
    @(negedge clk); src_en[9] = 0; check("R10 output next cycle", clk_en_out, 1);
    @(negedge clk); check("R10 single pulse", clk_en_out, 0);

    // R8 directed corners then random
    wr(4'h4, {8'h5A, 24'h001001});
    run(500, 9, 90, got, srcn); check("R8 just above one", got, exp_count(srcn, 24'h1001));
    wr(4'h4, {8'h5A, 24'h000800});
    run(300, 9, 50, got, srcn); check("R8 below one", got, exp_count(srcn, 24'h800));
    wr(4'h4, {8'h5A, 24'hFFFFFF});
    run(300, 9, 90, got, srcn); check("R8 max div", got, exp_count(srcn, 24'hFFFFFF));
    for (int k = 0; k < 24; k++) begin
      int sel;
      logic [23:0] d;
      sel = 1 + ($urandom % 15);
      d = {($urandom % 20), 12'h0} | ($urandom % 4096);
      if (k % 8 == 7) d = 0;
      wr(4'h4, {8'h5A, d});
      wr(4'h0, ctl_word(8'h5A, 0, 1, sel[3:0]));
      run(400 + ($urandom % 800), sel, 20 + ($urandom % 80), got, srcn);
      check("R8 random", got, exp_count(srcn, d));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule